// File: doc/BRIEF.md
# Mask-based identifier acceptance filter

This block decides whether a received message may be stored in the receive buffer. It compares the message against a 32-bit pattern, with one mask bit per pattern bit. The pattern is held in four 8-bit code registers and the mask in four 8-bit mask registers. The receive path presents the following on the check inputs and raises a one-cycle request:

- the frame format;
- the 29-bit identifier field;
- the remote-request flag;
- the data length code;
- the first two data bytes.

One cycle later the block raises a done pulse. The accept bit is valid in that cycle and keeps its value until the next check.

How message bits line up with the pattern depends on the frame format. For a standard frame the 11 identifier bits and the remote flag are compared, followed by the first two data bytes. A data byte that the message does not carry is not compared. For an extended frame all 29 identifier bits and the remote flag are compared. A single-filter mode bit enables the comparison. When that bit is 0, every message is accepted. Software loads the registers through a byte-wide write port. The port is active only while the configuration input is high.

Top module: `id_accept_filter`

## Requirements
- R1: After reset, `acc_done` and `acc_out` are 0. All code bytes reset to 0x00 and all mask bytes reset to 0xFF, so any message checked before a write is accepted.
- R2: A check request raised in one cycle makes `acc_done` high for exactly the next cycle. `acc_out` changes only in a cycle where `acc_done` is high.
- R3: Each compared bit accepts when its mask bit is 1 or when the message bit equals the code bit. A message is accepted only when every compared bit accepts.
- R4: Pattern bit 31 is bit 7 of code/mask byte 0, and pattern bit 0 is bit 0 of byte 3. Write address k (0..3) loads code byte k, and address 4+k loads mask byte k.
- R5: Standard frame (`chk_ext`=0) mapping:
  - pattern bits 31:21 compare with identifier bits 28:18 (`chk_id[28:18]`);
  - bit 20 compares with the remote flag;
  - bits 15:8 compare with data byte 1;
  - bits 7:0 compare with data byte 2.
- R6: For a standard frame, pattern bits 19:16 (the low nibble of byte 1) always accept.
- R7: For a standard frame with the remote flag set, or with DLC 0, neither data byte is compared. With DLC 1, only data byte 2 is skipped. With any DLC of 2 or more, including values above 8, both data bytes are compared.
- R8: Extended frame (`chk_ext`=1) mapping:
  - pattern bits 31:3 compare with identifier bits 28:0;
  - bit 2 compares with the remote flag;
  - bits 1:0 always accept.
- R9: A write while `cfg_en` is low changes no register.
- R10: When `single_mode` is 0 at the request, the message is accepted regardless of its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Configuration phase; enables register writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0..3 code byte, 4..7 mask byte |
| wr_data | input | 8 | Write data |
| single_mode | input | 1 | 1 = single 32-bit filter, 0 = accept all |
| chk_req | input | 1 | Check request, one cycle |
| chk_ext | input | 1 | 1 = extended frame, 0 = standard |
| chk_id | input | 29 | Identifier; standard uses bits 28:18 |
| chk_rtr | input | 1 | Remote request flag |
| chk_dlc | input | 4 | Data length code |
| chk_db1 | input | 8 | First data byte |
| chk_db2 | input | 8 | Second data byte |
| acc_out | output | 1 | Accept result |
| acc_done | output | 1 | Result valid pulse |

## Verification
The hardest cases to reach are the boundaries of the missing-data-byte rule. Each one pairs a mismatching data byte with a length that either hides that byte or leaves it compared: DLC 1 with data byte 2 wrong, DLC 1 with data byte 1 wrong, DLC 12, and the remote flag with DLC 8. The stimulus programs an all-zero mask so that each data byte matters. It then changes one byte at a time against the stored pattern. Garbage in the unused nibble and in the two unused extended bits shows that those positions are ignored. Writes issued with the configuration input low are followed by a mismatching check, which shows that the registers kept their values.

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
  parameter int BYTES  = 4,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             single_mode,
  input  logic             chk_req,
  input  logic             chk_ext,
  input  logic [ID_W-1:0]  chk_id,
  input  logic             chk_rtr,
  input  logic [DLC_W-1:0] chk_dlc,
  input  logic [7:0]       chk_db1,
  input  logic [7:0]       chk_db2,
  output logic             acc_out,
  output logic             acc_done
);
  localparam int W = 8 * BYTES;

  logic [7:0]   code_q [BYTES];
  logic [7:0]   mask_q [BYTES];
  logic [W-1:0] code_v, mask_v, msg_v, ign_v;
  logic         skip1, skip2, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < BYTES; k++) begin
        code_q[k] <= 8'h00;
        mask_q[k] <= 8'hFF;
      end
    end else if (cfg_en && wr_en) begin
      if (wr_addr[2]) mask_q[wr_addr[1:0]] <= wr_data;
      else            code_q[wr_addr[1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_pack
    assign code_v[W-1-8*g -: 8] = code_q[g];
    assign mask_v[W-1-8*g -: 8] = mask_q[g];
  end

  assign skip1 = chk_rtr || (chk_dlc == '0);
  assign skip2 = chk_rtr || (chk_dlc < DLC_W'(2));

  always_comb begin
    if (chk_ext) begin
      msg_v = {chk_id, chk_rtr, 2'b00};
      ign_v = 32'h0000_0003;
    end else begin
      msg_v = {chk_id[ID_W-1 -: 11], chk_rtr, 4'h0, chk_db1, chk_db2};
      ign_v = 32'h000F_0000 | (skip1 ? 32'h0000_FF00 : 32'h0)
                            | (skip2 ? 32'h0000_00FF : 32'h0);
    end
  end

  assign hit = &(mask_v | ign_v | ~(msg_v ^ code_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out  <= 1'b0;
      acc_done <= 1'b0;
    end else begin
      acc_done <= chk_req;
      if (chk_req) acc_out <= !single_mode || hit;
    end
  end
endmodule

module id_accept_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        single_mode,
  input logic        chk_req,
  input logic        acc_out,
  input logic        acc_done,
  input logic [31:0] code_v,
  input logic [31:0] mask_v
);
  a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> acc_done);
  a_r2_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_done) |-> $past(chk_req));
  a_r2_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_done |-> $stable(acc_out));
  a_r9_locked_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> ($stable(code_v) && $stable(mask_v)));
  a_r10_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !single_mode) |=> acc_out);
endmodule

bind id_accept_filter id_accept_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .single_mode(single_mode),
  .chk_req(chk_req), .acc_out(acc_out), .acc_done(acc_done),
  .code_v(code_v), .mask_v(mask_v)
);

// File: tb/sim_id_accept_filter.sv
module sim_id_accept_filter;
  logic clk = 0, rst_n = 0, cfg_en = 0, wr_en = 0, single_mode = 1;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic chk_req = 0, chk_ext = 0, chk_rtr = 0;
  logic [28:0] chk_id = 0;
  logic [3:0] chk_dlc = 0;
  logic [7:0] chk_db1 = 0, chk_db2 = 0;
  logic acc_out, acc_done;
  int runs = 0, fails = 0;

  localparam logic [10:0] SID = 11'h5A3;
  localparam logic [28:0] XID = 29'h1ABCDE12;
  localparam logic [7:0]  D1 = 8'h3C, D2 = 8'hC3;

  always #4 clk = ~clk;

  id_accept_filter u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [31:0] code, input logic [31:0] mask);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); wr_en = 1; wr_addr = 3'(k); wr_data = code[31-8*k -: 8];
      @(negedge clk); wr_addr = 3'(4+k); wr_data = mask[31-8*k -: 8];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic probe(input string tag, input logic ext, input logic [28:0] id,
                       input logic rtr, input logic [3:0] dlc,
                       input logic [7:0] b1, input logic [7:0] b2, input logic exp);
    @(negedge clk);
    chk_ext = ext; chk_id = id; chk_rtr = rtr; chk_dlc = dlc;
    chk_db1 = b1; chk_db2 = b2; chk_req = 1;
    @(negedge clk); chk_req = 0;
    chk({tag, " done"}, acc_done, 1'b1);
    chk(tag, acc_out, exp);
    @(negedge clk);
    chk({tag, " R2 single pulse"}, acc_done, 1'b0);
    chk({tag, " R2 held"}, acc_out, exp);
  endtask

  function automatic logic [28:0] sid(input logic [10:0] s);
    return {s, 18'h0};
  endfunction

  task automatic t_reset;
    chk("R1 done after reset", acc_done, 1'b0);
    chk("R1 acc after reset", acc_out, 1'b0);
    probe("R1 open masks", 0, sid(11'h7FF), 0, 4'd8, 8'h11, 8'h22, 1);
  endtask

  task automatic t_locked;
    cfg_en = 0;
    wr32(32'h0000_0000, 32'h0000_0000);
    probe("R9 write ignored", 0, sid(11'h7FF), 1, 4'd8, 8'hFF, 8'hFF, 1);
  endtask

  task automatic t_std;
    cfg_en = 1;
    wr32({SID, 1'b0, 4'h0, D1, D2}, 32'h0);
    cfg_en = 0;
    probe("R5 std match", 0, sid(SID), 0, 4'd8, D1, D2, 1);
    probe("R3 R5 id28 mismatch", 0, sid(SID ^ 11'h400), 0, 4'd8, D1, D2, 0);
    probe("R5 id18 mismatch", 0, sid(SID ^ 11'h001), 0, 4'd8, D1, D2, 0);
    probe("R5 db1 mismatch", 0, sid(SID), 0, 4'd8, D1 ^ 8'h01, D2, 0);
    probe("R5 db2 mismatch", 0, sid(SID), 0, 4'd8, D1, D2 ^ 8'h80, 0);
    probe("R7 dlc12 db2 compared", 0, sid(SID), 0, 4'd12, D1, D2 ^ 8'h01, 0);
    probe("R7 dlc0 no data", 0, sid(SID), 0, 4'd0, 8'h00, 8'h00, 1);
    probe("R7 dlc1 db2 skipped", 0, sid(SID), 0, 4'd1, D1, 8'h00, 1);
    probe("R7 dlc1 db1 compared", 0, sid(SID), 0, 4'd1, 8'h00, 8'h00, 0);
    probe("R5 rtr mismatch", 0, sid(SID), 1, 4'd8, D1, D2, 0);
  endtask

  task automatic t_std_misc;
    cfg_en = 1;
    wr32({SID, 1'b1, 4'hA, D1, D2}, 32'h0000_0000);
    cfg_en = 0;
    probe("R6 unused nibble", 0, sid(SID), 1, 4'd0, 8'h00, 8'h00, 1);
    probe("R7 rtr no data", 0, sid(SID), 1, 4'd8, 8'h5A, 8'hA5, 1);
    cfg_en = 1;
    wr32({SID, 1'b0, 4'h0, D1, D2}, 32'h0040_0000);
    cfg_en = 0;
    probe("R3 R4 mask dont care", 0, sid(SID ^ 11'h002), 0, 4'd8, D1, D2, 1);
    probe("R3 unmasked bit", 0, sid(SID ^ 11'h004), 0, 4'd8, D1, D2, 0);
  endtask

  task automatic t_ext;
    cfg_en = 1;
    wr32({XID, 1'b0, 2'b10}, 32'h0);
    cfg_en = 0;
    probe("R8 ext match", 1, XID, 0, 4'd8, 8'hFF, 8'h00, 1);
    probe("R8 id0 mismatch", 1, XID ^ 29'h1, 0, 4'd8, 8'hFF, 8'h00, 0);
    probe("R8 id28 mismatch", 1, XID ^ 29'h1000_0000, 0, 4'd0, 8'h00, 8'h00, 0);
    probe("R8 rtr mismatch", 1, XID, 1, 4'd0, 8'h00, 8'h00, 0);
  endtask

  task automatic t_dual;
    single_mode = 0;
    probe("R10 dual pass", 1, XID ^ 29'h7, 1, 4'd3, 8'h00, 8'h00, 1);
    single_mode = 1;
    probe("R10 back to single", 1, XID ^ 29'h7, 1, 4'd3, 8'h00, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_std;
    t_std_misc;
    t_ext;
    t_dual;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #400000;
    runs++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule